// File: doc/BRIEF.md
# Cursor and Icon Blink Compositor

This block sits between the character pattern lookup and the column drivers of a dot-matrix character display controller. For every character cell and dot row being scanned it takes the 5-dot glyph row and decides what actually reaches the columns. The decision depends on whether the cell is under the cursor, whether the scan is on an icon row, and which blink half-phase is active.

The blink half-phase comes from one prescaler fed by the oscillator enable. With the default divider the phase flips every 104448 oscillator ticks, which gives roughly a one-second blink period. The same phase drives both the cursor character blink and the icon blink. On icon rows the dots come from one of two icon source rows. The even source holds the steady icon states. The odd source holds the alternate states, and it is used only during the odd phase and only while icon blink is enabled. The cursor overlay is dropped whenever the address counter refers to pattern RAM instead of display RAM.

Top module: `lcd_blink_compositor`

## Requirements
- R1: The blink phase is even (0) after reset and inverts after every DIV oscillator ticks counted while the display is on; the default DIV is 104448.
- R2: Oscillator ticks are not counted while the display is off or the oscillator enable is low, so the phase holds its value.
- R3: The dot output is registered: it reflects the inputs one clock later, and it reads 5'b00000 during and right after reset.
- R4: With the display off, the dot output is 5'b00000.
- R5: On a character row, when the cell address equals the cursor address, the underline enable is set and the dot row index is 7 (the last row), all 5 dots are lit.
- R6: On a cursor cell with character blink enabled, the odd phase lights all 5 dots and the even phase shows the glyph row; underline and blink may be active together.
- R7: While the cursor pattern-RAM flag is set, neither the underline nor the character blink is applied, and the glyph row passes unchanged.
- R8: Cells whose address differs from the cursor address show the glyph row unchanged.
- R9: On an icon row, the even icon source row is shown when icon blink is disabled or the phase is even.
- R10: On an icon row, with icon blink enabled during the odd phase, the odd icon source row is shown, whatever the character blink enable is.
- R11: In icon-only mode, character rows output 5'b00000 while icon rows are still shown.

Whether a cell is under the cursor depends only on the address comparison, the cursor pattern-RAM flag and the scan kind (character row or icon row).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| osc_en | input | 1 | One-cycle oscillator tick enable |
| disp_on | input | 1 | Display enable |
| curs_ul_en | input | 1 | Cursor underline enable |
| curs_blk_en | input | 1 | Cursor character blink enable |
| icon_only | input | 1 | Icon-only display mode |
| icon_blk_en | input | 1 | Icon blink enable |
| cur_addr | input | 7 | Address counter value |
| cur_cg | input | 1 | Address counter refers to pattern RAM |
| cell_addr | input | 7 | Display address of the scanned cell |
| dot_row | input | 3 | Dot row index within the cell |
| row_is_icon | input | 1 | Current scan slot is an icon row |
| glyph_row | input | 5 | Glyph dots for this cell and row |
| icon_even_row | input | 5 | Icon states for the even/steady phase |
| icon_odd_row | input | 5 | Icon states for the odd blink phase |
| dot_out | output | 5 | Composited column dots |

## Verification
Random stimulus mixes cursor hits and misses, every dot row, both scan kinds and all mode bits, while the oscillator enable is held high most of the time so that many phase flips occur. This separates the underline row from the other rows, the odd-phase block from the even-phase glyph, and the even icon source from the odd one. Directed cases cover the reset phase, the pattern-RAM flag while the address matches, icon blink with character blink off, and a long stretch with the display off followed by a phase-sensitive cursor read. The last case shows whether ticks counted during display-off moved the phase.

// File: rtl/lcd_blink_pkg.sv
package lcd_blink_pkg;
  localparam int DOTS = 5;
  typedef logic [DOTS-1:0] dots_t;
  localparam dots_t ALL_ON  = '1;
  localparam dots_t ALL_OFF = '0;
endpackage

// File: rtl/blink_phase_gen.sv
module blink_phase_gen #(
  parameter int DIV = 104448
) (
  input  logic clk,
  input  logic rst,
  input  logic osc_en,
  input  logic disp_on,
  output logic phase_o
);
  localparam int CW = (DIV > 2) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt;
  logic          tick;

  assign tick = osc_en && disp_on;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= '0;
      phase_o <= 1'b0;
    end else if (tick) begin
      if (cnt == LAST) begin
        cnt     <= '0;
        phase_o <= ~phase_o;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  a_r2_hold_when_idle: assert property (@(posedge clk) disable iff (rst)
    !(osc_en && disp_on) |=> $stable(phase_o));
  a_r1_no_early_flip: assert property (@(posedge clk) disable iff (rst)
    (tick && cnt != LAST) |=> $stable(phase_o));
  a_r1_flip_at_wrap: assert property (@(posedge clk) disable iff (rst)
    (tick && cnt == LAST) |=> (phase_o != $past(phase_o)));
  a_r1_count_bound: assert property (@(posedge clk) disable iff (rst)
    cnt <= LAST);
endmodule

// File: rtl/cursor_overlay.sv
module cursor_overlay
  import lcd_blink_pkg::*;
(
  input  dots_t glyph,
  input  logic  hit,
  input  logic  ul_en,
  input  logic  blk_en,
  input  logic  ul_row,
  input  logic  phase,
  output dots_t dots
);
  logic block_on;
  logic line_on;

  assign block_on = hit && blk_en && phase;
  assign line_on  = hit && ul_en && ul_row;

  always_comb begin
    dots = glyph;
    if (block_on || line_on) dots = ALL_ON;
  end
endmodule

// File: rtl/icon_select.sv
module icon_select
  import lcd_blink_pkg::*;
(
  input  dots_t even_src,
  input  dots_t odd_src,
  input  logic  blink_en,
  input  logic  phase,
  output dots_t dots
);
  assign dots = (blink_en && phase) ? odd_src : even_src;
endmodule

// File: rtl/lcd_blink_compositor.sv
module lcd_blink_compositor
  import lcd_blink_pkg::*;
#(
  parameter int DIV    = 104448,
  parameter int ADDR_W = 7,
  parameter int ROW_W  = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              osc_en,
  input  logic              disp_on,
  input  logic              curs_ul_en,
  input  logic              curs_blk_en,
  input  logic              icon_only,
  input  logic              icon_blk_en,
  input  logic [ADDR_W-1:0] cur_addr,
  input  logic              cur_cg,
  input  logic [ADDR_W-1:0] cell_addr,
  input  logic [ROW_W-1:0]  dot_row,
  input  logic              row_is_icon,
  input  logic [DOTS-1:0]   glyph_row,
  input  logic [DOTS-1:0]   icon_even_row,
  input  logic [DOTS-1:0]   icon_odd_row,
  output logic [DOTS-1:0]   dot_out
);
  localparam logic [ROW_W-1:0] UL_ROW = '1;

  logic  phase;
  logic  hit;
  dots_t chr_dots;
  dots_t ico_dots;
  dots_t next_dots;

  blink_phase_gen #(.DIV(DIV)) u_phase (
    .clk    (clk),
    .rst    (rst),
    .osc_en (osc_en),
    .disp_on(disp_on),
    .phase_o(phase)
  );

  assign hit = !cur_cg && (cell_addr == cur_addr);

  cursor_overlay u_curs (
    .glyph (glyph_row),
    .hit   (hit),
    .ul_en (curs_ul_en),
    .blk_en(curs_blk_en),
    .ul_row(dot_row == UL_ROW),
    .phase (phase),
    .dots  (chr_dots)
  );

  icon_select u_icon (
    .even_src(icon_even_row),
    .odd_src (icon_odd_row),
    .blink_en(icon_blk_en),
    .phase   (phase),
    .dots    (ico_dots)
  );

  always_comb begin
    if (!disp_on)         next_dots = ALL_OFF;
    else if (row_is_icon) next_dots = ico_dots;
    else if (icon_only)   next_dots = ALL_OFF;
    else                  next_dots = chr_dots;
  end

  always_ff @(posedge clk) begin
    if (rst) dot_out <= ALL_OFF;
    else     dot_out <= next_dots;
  end

  a_r4_dark_when_off: assert property (@(posedge clk) disable iff (rst)
    !disp_on |=> dot_out == '0);
  a_r7_cg_passes_glyph: assert property (@(posedge clk) disable iff (rst)
    (disp_on && cur_cg && !row_is_icon && !icon_only) |=> dot_out == $past(glyph_row));
  a_r9_steady_icon: assert property (@(posedge clk) disable iff (rst)
    (disp_on && row_is_icon && !icon_blk_en) |=> dot_out == $past(icon_even_row));
  a_r11_icon_only_blank: assert property (@(posedge clk) disable iff (rst)
    (disp_on && icon_only && !row_is_icon) |=> dot_out == '0);
  a_r8_miss_passes_glyph: assert property (@(posedge clk) disable iff (rst)
    (disp_on && !icon_only && !row_is_icon && cell_addr != cur_addr) |=> dot_out == $past(glyph_row));
endmodule

// File: tb/lcd_blink_compositor_bench.sv
module lcd_blink_compositor_bench;
  localparam int DIV = 5;

  logic clk = 1'b0;
  logic rst;
  logic osc_en, disp_on, curs_ul_en, curs_blk_en, icon_only, icon_blk_en;
  logic [6:0] cur_addr, cell_addr;
  logic cur_cg, row_is_icon;
  logic [2:0] dot_row;
  logic [4:0] glyph_row, icon_even_row, icon_odd_row;
  logic [4:0] dot_out;

  int nvec = 0;
  int nfail = 0;
  int m_cnt = 0;
  bit m_phase = 1'b0;
  string tag;
  string ovr = "";

  always #10 clk = ~clk;

  lcd_blink_compositor #(.DIV(DIV)) u_lcd_blink_compositor (
    .clk(clk), .rst(rst), .osc_en(osc_en), .disp_on(disp_on),
    .curs_ul_en(curs_ul_en), .curs_blk_en(curs_blk_en),
    .icon_only(icon_only), .icon_blk_en(icon_blk_en),
    .cur_addr(cur_addr), .cur_cg(cur_cg), .cell_addr(cell_addr),
    .dot_row(dot_row), .row_is_icon(row_is_icon), .glyph_row(glyph_row),
    .icon_even_row(icon_even_row), .icon_odd_row(icon_odd_row),
    .dot_out(dot_out)
  );

  function automatic logic [4:0] model();
    logic hitm;
    hitm = !cur_cg && (cell_addr == cur_addr);
    if (!disp_on) begin tag = "R4"; return 5'b0; end
    if (row_is_icon) begin
      if (icon_blk_en && m_phase) begin tag = "R10"; return icon_odd_row; end
      tag = "R9"; return icon_even_row;
    end
    if (icon_only) begin tag = "R11"; return 5'b0; end
    if (cur_cg) begin tag = "R7"; return glyph_row; end
    if (!hitm) begin tag = "R8"; return glyph_row; end
    if (curs_ul_en && dot_row == 3'd7) begin tag = "R5"; return 5'h1F; end
    if (curs_blk_en) begin
      tag = "R6";
      return m_phase ? 5'h1F : glyph_row;
    end
    tag = "R8";
    return glyph_row;
  endfunction

  task automatic step();
    logic [4:0] exp;
    exp = model();
    if (ovr != "") tag = ovr;
    if (osc_en && disp_on) begin
      if (m_cnt == DIV - 1) begin m_cnt = 0; m_phase = ~m_phase; end
      else m_cnt = m_cnt + 1;
    end
    @(negedge clk);
    nvec++;
    if (dot_out !== exp) begin
      nfail++;
      $display("FAIL %s: dot_out got %b expected %b", tag, dot_out, exp);
    end
  endtask

  task automatic idle_defaults();
    osc_en = 1'b1; disp_on = 1'b1; curs_ul_en = 1'b0; curs_blk_en = 1'b0;
    icon_only = 1'b0; icon_blk_en = 1'b0; cur_addr = 7'h05; cur_cg = 1'b0;
    cell_addr = 7'h05; dot_row = 3'd2; row_is_icon = 1'b0;
    glyph_row = 5'b01010; icon_even_row = 5'b00111; icon_odd_row = 5'b11000;
  endtask

  initial begin
    #(200000 * 20);
    nfail++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

  initial begin
    void'($urandom(32'h1234ABCD));
    idle_defaults();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    nvec++;
    if (dot_out !== 5'b0) begin
      nfail++;
      $display("FAIL R3: reset dot_out got %b expected 00000", dot_out);
    end
    rst = 1'b0;

    // R1: even phase after reset, blink on a cursor cell shows the glyph
    curs_blk_en = 1'b1; osc_en = 1'b0; ovr = "R1";
    step();
    ovr = "";
    // R5: underline on last row, R6 combined with blink
    curs_ul_en = 1'b1; dot_row = 3'd7; step();
    dot_row = 3'd6; step();
    // R7: pattern-RAM flag suppresses underline and blink
    cur_cg = 1'b1; dot_row = 3'd7; step();
    cur_cg = 1'b0;
    // R1/R6: run to odd phase and observe the block
    osc_en = 1'b1; dot_row = 3'd3; curs_ul_en = 1'b0;
    repeat (DIV + 2) step();
    // R10: icon blink with character blink off
    curs_blk_en = 1'b0; icon_blk_en = 1'b1; row_is_icon = 1'b1;
    repeat (2 * DIV) step();
    // R11: icon-only mode, both slot kinds
    icon_only = 1'b1; row_is_icon = 1'b0; step();
    row_is_icon = 1'b1; step();
    icon_only = 1'b0; row_is_icon = 1'b0;
    // R2/R4: display off for many ticks, then phase must be unchanged
    disp_on = 1'b0; repeat (3 * DIV + 1) step();
    disp_on = 1'b1; osc_en = 1'b0; curs_blk_en = 1'b1; ovr = "R2";
    step();
    osc_en = 1'b1; row_is_icon = 1'b1; step();
    ovr = ""; row_is_icon = 1'b0;

    // Random mix
    for (int i = 0; i < 4000; i++) begin
      osc_en      = ($urandom % 8) != 0;
      disp_on     = ($urandom % 16) != 0;
      curs_ul_en  = $urandom;
      curs_blk_en = $urandom;
      icon_only   = ($urandom % 6) == 0;
      icon_blk_en = $urandom;
      cur_cg      = ($urandom % 5) == 0;
      cur_addr    = $urandom % 8;
      cell_addr   = $urandom % 8;
      dot_row     = $urandom;
      row_is_icon = ($urandom % 4) == 0;
      glyph_row   = $urandom;
      icon_even_row = $urandom;
      icon_odd_row  = $urandom;
      step();
    end

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end
endmodule